// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Resolver

This block sits in front of the arithmetic datapath of a double-precision fused multiply-add that computes `z + x*y`, or `z - x*y` when the product-negate input is set. It sorts each of the three 64-bit operands into one of six classes: signalling NaN, quiet NaN, infinity, zero, denormal or normal. From those classes it either produces the final answer itself or passes the operation on to the multiplier, adder and rounder.

When the outcome follows from the operand classes alone, the block raises `bypass_valid` and drives the answer on `bypass_result`. It also drives `invalid_flag` when the operation is invalid. In every other case it raises `compute_en`, and the datapath produces the result. The block is purely combinational. Its outputs follow its inputs within the same cycle.

Top module: `fma_special_resolver`

## Requirements
- R1: Exactly one of `bypass_valid` and `compute_en` is high for any input. `compute_en` is high only when no operand is a NaN, `x` and `y` are both finite and nonzero, and `z` is finite. Denormals count as finite and nonzero. In that case `invalid_flag` is 0.
- R2: When any operand is a NaN, the NaN that is returned is chosen by a fixed order. Signalling NaNs come first, checked in `z`, `x`, `y` order. Quiet NaNs follow, checked in the same order. NaN handling takes precedence over every other rule.
- R3: When the chosen NaN is signalling, `invalid_flag` is 1. The result is that operand with fraction bit 51 set, so its sign and payload are kept. A NaN has exponent bits 62..52 all ones and a nonzero fraction. Fraction bit 51 set means quiet, and clear means signalling.
- R4: When the chosen NaN is quiet, the result is that operand unchanged and `invalid_flag` is 0.
- R5: An infinity multiplied by a zero, in either operand order, raises `invalid_flag` and returns the default NaN `0x7FF8000000000000`.
- R6: The product sign is `x[63] ^ y[63] ^ negate_prod`. An infinite product returns infinity with the product sign, encoded as `{sign, 11'h7FF, 52'h0}`, unless R7 applies.
- R7: An infinite product added to a `z` infinity of the opposite sign raises `invalid_flag` and returns the default NaN.
- R8: A zero product returns `z` exactly when `z` is infinite, normal or denormal.
- R9: A zero product with a zero `z` returns `z` when the two signs match. When they differ, the result is a zero whose sign bit is 1 only when `round_mode` is `2'b11` (toward negative). The encodings `2'b00`, `2'b01` and `2'b10` give `+0`.
- R10: A finite nonzero product with an infinite `z` returns `z` with no invalid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_z | input | 64 | Addend, binary64 |
| op_x | input | 64 | First multiplicand, binary64 |
| op_y | input | 64 | Second multiplicand, binary64 |
| negate_prod | input | 1 | Negate the product before the addition |
| round_mode | input | 2 | Rounding mode; `2'b11` is toward negative |
| bypass_valid | output | 1 | The result is resolved here |
| bypass_result | output | 64 | Resolved result; zero when not bypassing |
| invalid_flag | output | 1 | Invalid-operation exception |
| compute_en | output | 1 | Hand the operation to the arithmetic datapath |

## Verification
The bench puts NaNs of both kinds into several operand slots at once. A priority chain built in the wrong order, or one that quiets a NaN that is already quiet, would then return the wrong payload or a wrong flag. It drives infinity times zero both with and without a NaN present, so that an invalid raised ahead of the NaN rule is exposed. It flips `negate_prod` against infinite and zero addends, because a sign computed without the negation turns a valid infinity into an invalid one, and the reverse. It sweeps all four rounding modes on cancelling zeros, where a decoder that reads a single bit of the mode would give `-0` in the wrong mode.

// File: rtl/fma_spec_pkg.sv
package fma_spec_pkg;

    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int DATA_W = 1 + EXP_W + FRAC_W;

    typedef enum logic [2:0] {
        CLS_ZERO  = 3'd0,
        CLS_DNORM = 3'd1,
        CLS_NORM  = 3'd2,
        CLS_INF   = 3'd3,
        CLS_QNAN  = 3'd4,
        CLS_SNAN  = 3'd5
    } fp_class_e;

    typedef struct packed {
        logic              sign;
        fp_class_e         cls;
        logic [DATA_W-1:0] raw;
    } opnd_t;

    typedef struct packed {
        logic              found;
        logic              invalid;
        logic [DATA_W-1:0] value;
    } nan_pick_t;

    typedef struct packed {
        logic              bypass;
        logic              invalid;
        logic              compute;
        logic [DATA_W-1:0] value;
    } decision_t;

    function automatic logic is_nan(input fp_class_e c);
        return (c == CLS_QNAN) || (c == CLS_SNAN);
    endfunction

    function automatic logic is_finite_nonzero(input fp_class_e c);
        return (c == CLS_NORM) || (c == CLS_DNORM);
    endfunction

    function automatic logic [DATA_W-1:0] make_inf(input logic s);
        return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    endfunction

    function automatic logic [DATA_W-1:0] make_zero(input logic s);
        return {s, {(DATA_W-1){1'b0}}};
    endfunction

endpackage

// File: rtl/fma_operand_classifier.sv
module fma_operand_classifier
    import fma_spec_pkg::*;
#(
    parameter int QUIET_BIT = 51
) (
    input  logic [DATA_W-1:0] operand,
    output opnd_t             info
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_max;
    logic              exp_min;
    logic              frac_nz;

    assign exp_f   = operand[DATA_W-2 -: EXP_W];
    assign frac_f  = operand[FRAC_W-1:0];
    assign exp_max = &exp_f;
    assign exp_min = ~|exp_f;
    assign frac_nz = |frac_f;

    always_comb begin
        info.sign = operand[DATA_W-1];
        info.raw  = operand;
        if (exp_max && frac_nz)
            info.cls = frac_f[QUIET_BIT] ? CLS_QNAN : CLS_SNAN;
        else if (exp_max)
            info.cls = CLS_INF;
        else if (exp_min && frac_nz)
            info.cls = CLS_DNORM;
        else if (exp_min)
            info.cls = CLS_ZERO;
        else
            info.cls = CLS_NORM;
    end

    // R3: a value classed as a NaN must carry a nonzero fraction
    always_comb begin
        p_nan_has_payload_r3: assert (!is_nan(info.cls) || (info.raw[FRAC_W-1:0] != '0))
            else $error("classified NaN with empty fraction");
    end

endmodule

// File: rtl/fma_nan_arbiter.sv
module fma_nan_arbiter
    import fma_spec_pkg::*;
#(
    parameter int N_OPS     = 3,
    parameter int QUIET_BIT = 51
) (
    input  opnd_t     ops [N_OPS],
    output nan_pick_t pick
);
    localparam int N_GRANT = 2 * N_OPS;

    logic [N_OPS-1:0]   snan_hit;
    logic [N_OPS-1:0]   qnan_hit;
    logic [N_GRANT-1:0] grant;
    logic [DATA_W-1:0]  quiet_mask;

    assign quiet_mask = {{(DATA_W-1){1'b0}}, 1'b1} << QUIET_BIT;

    genvar gi;
    generate
        for (gi = 0; gi < N_OPS; gi++) begin : g_hit
            assign snan_hit[gi] = (ops[gi].cls == CLS_SNAN);
            assign qnan_hit[gi] = (ops[gi].cls == CLS_QNAN);
        end
    endgenerate

    // priority: signalling before quiet, lower index (z, x, y) first
    always_comb begin
        grant = '0;
        for (int i = N_OPS - 1; i >= 0; i--) begin
            if (qnan_hit[i]) grant = '0;
            if (qnan_hit[i]) grant[N_OPS + i] = 1'b1;
        end
        for (int i = N_OPS - 1; i >= 0; i--) begin
            if (snan_hit[i]) grant = '0;
            if (snan_hit[i]) grant[i] = 1'b1;
        end
    end

    always_comb begin
        pick.found   = |grant;
        pick.invalid = |grant[N_OPS-1:0];
        pick.value   = '0;
        for (int i = 0; i < N_OPS; i++) begin
            if (grant[i])         pick.value = ops[i].raw | quiet_mask;
            if (grant[N_OPS + i]) pick.value = ops[i].raw;
        end
    end

    // R2: at most one NaN source is ever selected
    always_comb begin
        p_single_grant_r2: assert ($onehot0(grant))
            else $error("more than one NaN source granted");
    end

    // R4: any NaN returned here leaves as a quiet NaN
    always_comb begin
        p_quiet_out_r4: assert (!pick.found ||
                                (pick.value[QUIET_BIT] && (&pick.value[DATA_W-2 -: EXP_W])))
            else $error("returned NaN is not quiet");
    end

endmodule

// File: rtl/fma_special_decider.sv
module fma_special_decider
    import fma_spec_pkg::*;
#(
    parameter logic [DATA_W-1:0] DEFAULT_NAN   = 64'h7FF8_0000_0000_0000,
    parameter logic [1:0]        RM_TOWARD_NEG = 2'b11
) (
    input  opnd_t     z_op,
    input  logic      x_sign,
    input  fp_class_e x_cls,
    input  logic      y_sign,
    input  fp_class_e y_cls,
    input  logic      negate_prod,
    input  logic [1:0] round_mode,
    output decision_t dec
);
    logic prod_sign;
    logic prod_inf;
    logic prod_zero;
    logic z_inf;
    logic z_zero;

    assign prod_sign = x_sign ^ y_sign ^ negate_prod;
    assign prod_inf  = (x_cls == CLS_INF)  || (y_cls == CLS_INF);
    assign prod_zero = (x_cls == CLS_ZERO) || (y_cls == CLS_ZERO);
    assign z_inf     = (z_op.cls == CLS_INF);
    assign z_zero    = (z_op.cls == CLS_ZERO);

    always_comb begin
        dec.bypass  = 1'b1;
        dec.invalid = 1'b0;
        dec.compute = 1'b0;
        dec.value   = '0;
        if (prod_inf && prod_zero) begin
            dec.invalid = 1'b1;
            dec.value   = DEFAULT_NAN;
        end else if (prod_inf) begin
            if (z_inf && (z_op.sign != prod_sign)) begin
                dec.invalid = 1'b1;
                dec.value   = DEFAULT_NAN;
            end else begin
                dec.value = make_inf(prod_sign);
            end
        end else if (prod_zero) begin
            if (z_zero && (z_op.sign != prod_sign))
                dec.value = make_zero(round_mode == RM_TOWARD_NEG);
            else
                dec.value = z_op.raw;
        end else if (z_inf) begin
            dec.value = z_op.raw;
        end else begin
            dec.bypass  = 1'b0;
            dec.compute = 1'b1;
        end
    end

    // R6: an infinity built from the product carries the product sign
    always_comb begin
        p_inf_sign_r6: assert (!(dec.bypass && prod_inf && !dec.invalid) ||
                               (dec.value[DATA_W-1] == prod_sign))
            else $error("infinite product sign wrong");
    end

    // R9: a zero result never takes a sign absent from both inputs and the mode
    always_comb begin
        p_zero_sign_r9: assert (!(dec.bypass && prod_zero && z_zero && dec.value[DATA_W-1]) ||
                                (z_op.sign || (round_mode == RM_TOWARD_NEG)))
            else $error("negative zero without cause");
    end

endmodule

// File: rtl/fma_special_resolver.sv
module fma_special_resolver
    import fma_spec_pkg::*;
#(
    parameter logic [DATA_W-1:0] DEFAULT_NAN   = 64'h7FF8_0000_0000_0000,
    parameter int                QUIET_BIT     = 51,
    parameter logic [1:0]        RM_TOWARD_NEG = 2'b11
) (
    input  logic [DATA_W-1:0] op_z,
    input  logic [DATA_W-1:0] op_x,
    input  logic [DATA_W-1:0] op_y,
    input  logic              negate_prod,
    input  logic [1:0]        round_mode,
    output logic              bypass_valid,
    output logic [DATA_W-1:0] bypass_result,
    output logic              invalid_flag,
    output logic              compute_en
);
    localparam int N_OPS = 3;
    localparam int IDX_Z = 0;
    localparam int IDX_X = 1;
    localparam int IDX_Y = 2;

    logic [DATA_W-1:0] raw_ops [N_OPS];
    opnd_t             ops     [N_OPS];
    nan_pick_t         nan_sel;
    decision_t         dec;

    assign raw_ops[IDX_Z] = op_z;
    assign raw_ops[IDX_X] = op_x;
    assign raw_ops[IDX_Y] = op_y;

    genvar gi;
    generate
        for (gi = 0; gi < N_OPS; gi++) begin : g_cls
            fma_operand_classifier #(
                .QUIET_BIT (QUIET_BIT)
            ) i_cls (
                .operand (raw_ops[gi]),
                .info    (ops[gi])
            );
        end
    endgenerate

    fma_nan_arbiter #(
        .N_OPS     (N_OPS),
        .QUIET_BIT (QUIET_BIT)
    ) i_nan (
        .ops  (ops),
        .pick (nan_sel)
    );

    fma_special_decider #(
        .DEFAULT_NAN   (DEFAULT_NAN),
        .RM_TOWARD_NEG (RM_TOWARD_NEG)
    ) i_dec (
        .z_op        (ops[IDX_Z]),
        .x_sign      (ops[IDX_X].sign),
        .x_cls       (ops[IDX_X].cls),
        .y_sign      (ops[IDX_Y].sign),
        .y_cls       (ops[IDX_Y].cls),
        .negate_prod (negate_prod),
        .round_mode  (round_mode),
        .dec         (dec)
    );

    always_comb begin
        if (nan_sel.found) begin
            bypass_valid  = 1'b1;
            bypass_result = nan_sel.value;
            invalid_flag  = nan_sel.invalid;
            compute_en    = 1'b0;
        end else begin
            bypass_valid  = dec.bypass;
            bypass_result = dec.value;
            invalid_flag  = dec.invalid;
            compute_en    = dec.compute;
        end
    end

    // R1: the block either resolves or hands off, never both, never neither
    always_comb begin
        p_handoff_r1: assert (bypass_valid ^ compute_en)
            else $error("bypass and compute not exclusive");
    end

    // R1: hand-off only with all operands free of NaN and infinity
    always_comb begin
        p_compute_clean_r1: assert (!compute_en ||
                                    (!is_nan(ops[IDX_Z].cls) && ops[IDX_Z].cls != CLS_INF &&
                                     is_finite_nonzero(ops[IDX_X].cls) &&
                                     is_finite_nonzero(ops[IDX_Y].cls)))
            else $error("compute enabled on special operand");
    end

    // R5: invalid always comes with a NaN result
    always_comb begin
        p_invalid_nan_r5: assert (!invalid_flag ||
                                  ((&bypass_result[DATA_W-2 -: EXP_W]) &&
                                   (bypass_result[FRAC_W-1:0] != '0)))
            else $error("invalid flagged without NaN result");
    end

endmodule

// File: tb/test_fma_special_resolver.sv
module test_fma_special_resolver;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    localparam logic [63:0] PZ   = 64'h0000_0000_0000_0000;
    localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
    localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] MONE = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] TWO  = 64'h4000_0000_0000_0000;
    localparam logic [63:0] MTWO = 64'hC000_0000_0000_0000;
    localparam logic [63:0] DEN  = 64'h0000_0000_0000_0001;
    localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] DNAN = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] SN_A = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] SN_A_Q = 64'h7FF8_0000_0000_0001;
    localparam logic [63:0] SN_B = 64'hFFF4_0000_0000_0000;
    localparam logic [63:0] SN_B_Q = 64'hFFFC_0000_0000_0000;
    localparam logic [63:0] SN_C = 64'h7FF0_0000_0000_00C0;
    localparam logic [63:0] SN_C_Q = 64'h7FF8_0000_0000_00C0;
    localparam logic [63:0] QN_A = 64'h7FF8_0000_0000_0002;
    localparam logic [63:0] QN_B = 64'hFFF8_0000_0000_0300;
    localparam logic [63:0] QN_C = 64'h7FFF_0000_0000_0000;

    typedef struct {
        logic        bv;
        logic [63:0] res;
        logic        inv;
        logic        ce;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] op_z = '0;
    logic [63:0] op_x = '0;
    logic [63:0] op_y = '0;
    logic        negate_prod = 1'b0;
    logic [1:0]  round_mode = 2'b00;
    logic        bypass_valid;
    logic [63:0] bypass_result;
    logic        invalid_flag;
    logic        compute_en;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fma_special_resolver i_fma_special_resolver (
        .op_z          (op_z),
        .op_x          (op_x),
        .op_y          (op_y),
        .negate_prod   (negate_prod),
        .round_mode    (round_mode),
        .bypass_valid  (bypass_valid),
        .bypass_result (bypass_result),
        .invalid_flag  (invalid_flag),
        .compute_en    (compute_en)
    );

    task automatic send(input logic [63:0] z, input logic [63:0] x, input logic [63:0] y,
                        input logic neg, input logic [1:0] rm,
                        input logic e_bv, input logic [63:0] e_res, input logic e_inv,
                        input string tag);
        exp_t it;
        @(negedge clk);
        op_z = z; op_x = x; op_y = y; negate_prod = neg; round_mode = rm;
        it.bv = e_bv; it.res = e_res; it.inv = e_inv; it.ce = !e_bv; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // monitor: inputs change at negedge, compare at the following posedge
    always @(posedge clk) begin
        if (!rst && exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            n_tests++;
            if (bypass_valid !== it.bv || bypass_result !== it.res ||
                invalid_flag !== it.inv || compute_en !== it.ce) begin
                n_fail++;
                $display("FAIL %s: got bv=%0b res=%h inv=%0b ce=%0b, expected bv=%0b res=%h inv=%0b ce=%0b",
                         it.tag, bypass_valid, bypass_result, invalid_flag, compute_en,
                         it.bv, it.res, it.inv, it.ce);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // reset/idle inputs: +0 + (+0 * +0) resolves to +0 (R9)
        send(PZ, PZ, PZ, 0, 2'b00, 1, PZ, 0, "R9 idle zeros");

        // R1: hand-off for ordinary and denormal operands
        send(ONE, TWO, ONE, 0, 2'b00, 0, PZ, 0, "R1 normal operands");
        send(DEN, DEN, ONE, 1, 2'b11, 0, PZ, 0, "R1 denormal operands");
        send(PZ, MTWO, DEN, 0, 2'b00, 0, PZ, 0, "R1 zero addend computes");

        // R2 ordering
        send(QN_A, SN_B, ONE, 0, 2'b00, 1, SN_B_Q, 1, "R2 sNaN x beats qNaN z");
        send(SN_A, SN_B, SN_C, 0, 2'b00, 1, SN_A_Q, 1, "R2 sNaN z first");
        send(ONE, SN_B, SN_C, 0, 2'b00, 1, SN_B_Q, 1, "R2 sNaN x before y");
        send(ONE, QN_B, QN_C, 0, 2'b00, 1, QN_B, 0, "R2 qNaN x before y");
        send(QN_A, ONE, SN_C, 0, 2'b00, 1, SN_C_Q, 1, "R2 sNaN y beats qNaN z");
        send(PINF, PINF, QN_C, 0, 2'b00, 1, QN_C, 0, "R2 qNaN y over inf");
        send(QN_A, PINF, PZ, 0, 2'b00, 1, QN_A, 0, "R2 NaN over inf*0");

        // R3 / R4
        send(ONE, SN_B, TWO, 0, 2'b00, 1, SN_B_Q, 1, "R3 negative sNaN quieted");
        send(QN_A, ONE, ONE, 1, 2'b11, 1, QN_A, 0, "R4 qNaN z unchanged");

        // R5
        send(ONE, PINF, PZ, 0, 2'b00, 1, DNAN, 1, "R5 inf*0");
        send(NINF, NZ, NINF, 1, 2'b00, 1, DNAN, 1, "R5 0*inf");

        // R6
        send(ONE, PINF, ONE, 0, 2'b00, 1, PINF, 0, "R6 +inf product");
        send(ONE, NINF, ONE, 0, 2'b00, 1, NINF, 0, "R6 -inf product");
        send(ONE, NINF, ONE, 1, 2'b00, 1, PINF, 0, "R6 negated -inf product");
        send(NINF, PINF, NINF, 0, 2'b00, 1, NINF, 0, "R6 inf*inf with same-sign z");

        // R7
        send(NINF, PINF, ONE, 0, 2'b00, 1, DNAN, 1, "R7 +inf + -inf");
        send(PINF, PINF, ONE, 1, 2'b00, 1, DNAN, 1, "R7 negated product vs +inf");
        send(NINF, PINF, ONE, 1, 2'b00, 1, NINF, 0, "R7 negated product matches z");

        // R8
        send(PINF, PZ, TWO, 0, 2'b00, 1, PINF, 0, "R8 zero product, +inf z");
        send(NINF, TWO, NZ, 1, 2'b00, 1, NINF, 0, "R8 zero product, -inf z");
        send(ONE, PZ, TWO, 1, 2'b11, 1, ONE, 0, "R8 zero product, normal z");
        send(MTWO, DEN, NZ, 0, 2'b00, 1, MTWO, 0, "R8 zero product, negative z");
        send(DEN, NZ, NZ, 0, 2'b00, 1, DEN, 0, "R8 zero product, denormal z");

        // R9
        send(PZ, PZ, MONE, 0, 2'b00, 1, PZ, 0, "R9 cancel rm=00");
        send(PZ, PZ, MONE, 0, 2'b01, 1, PZ, 0, "R9 cancel rm=01");
        send(PZ, PZ, MONE, 0, 2'b10, 1, PZ, 0, "R9 cancel rm=10");
        send(PZ, PZ, MONE, 0, 2'b11, 1, NZ, 0, "R9 cancel rm=11");
        send(NZ, PZ, MONE, 0, 2'b00, 1, NZ, 0, "R9 matching -0 keeps z");
        send(PZ, PZ, ONE, 1, 2'b11, 1, NZ, 0, "R9 negated cancel rm=11");
        send(NZ, PZ, ONE, 1, 2'b10, 1, NZ, 0, "R9 negated match keeps -0");

        // R10
        send(NINF, ONE, TWO, 0, 2'b00, 1, NINF, 0, "R10 finite product, -inf z");
        send(PINF, DEN, MONE, 1, 2'b11, 1, PINF, 0, "R10 denormal product, +inf z");

        while (exp_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule